// File: doc/BRIEF.md
# Mixed-Width True Dual-Port RAM

An 18-kilobit storage block with two fully independent ports, A and B. Each port has its own clock, enable, write enable, output-clear input, address, write data, write parity, read data and read parity. A per-port parameter selects the aspect ratio of that port, so the same 16 Kbit data space and 2 Kbit parity space can be written at one width and read at another. The block therefore doubles as a width converter, parity bits included.

Reads and writes are synchronous to the port's own clock, with a one-cycle registered output. A write also loads the written word into the output register. The output register of each port can be cleared synchronously. The storage can be given a computed initial image at elaboration, so a design can read meaningful contents before any write.

Top module: `mwTdpRam`

## Requirements
- R1: The parameter MODE_x (0..5) sets port x to 16384x1, 8192x2, 4096x4, 2048x9, 1024x18 or 512x36. The data width is 2^MODE, the address width is 14-MODE, and the data ports carry exactly that many bits.
- R2: Modes 3, 4 and 5 carry 1, 2 and 4 parity bits per word, respectively. Modes 0 to 2 have a one-bit parity port, and its output always reads 0.
- R3: Word k of a port with data width W occupies bits k*W to k*W+W-1 of the shared 16384-bit data space. Bit 0 of the word is the lowest bit.
- R4: Word k of a port with P parity bits occupies bits k*P to k*P+P-1 of the shared 2048-bit parity space. Bit 0 of the word is the lowest bit.
- R5: Data written through one port can be read through the other port at the other port's width, starting with the first read clocked after the write edge.
- R6: With en high, we low and rstOut low, the output register holds the addressed word one clock edge later.
- R7: With en and we high, the addressed word is written. On the same edge the output register loads the written data and parity.
- R8: With en low, the port performs no write whatever we is, and its output register holds its value.
- R9: With en and rstOut high, the output register becomes all zeros on that edge. A write requested on the same edge still happens.
- R10: With en low, rstOut has no effect.
- R11: With INIT_ON set, the 36-bit row r (r = 0..511) starts as INIT_XOR ^ (r << 16) ^ r. Row bits 31:0 are data bits 32r..32r+31. Row bits 35:32 are parity bits 4r..4r+3. With INIT_ON clear, the storage starts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port A clock |
| enA | input | 1 | Port A enable |
| weA | input | 1 | Port A write enable |
| rstOutA | input | 1 | Port A synchronous output-register clear |
| addrA | input | 14-MODE_A | Port A word address |
| dinA | input | 2^MODE_A | Port A write data |
| pinA | input | max(parity,1) | Port A write parity |
| doutA | output | 2^MODE_A | Port A read data |
| poutA | output | max(parity,1) | Port A read parity |
| clkB | input | 1 | Port B clock |
| enB | input | 1 | Port B enable |
| weB | input | 1 | Port B write enable |
| rstOutB | input | 1 | Port B synchronous output-register clear |
| addrB | input | 14-MODE_B | Port B word address |
| dinB | input | 2^MODE_B | Port B write data |
| pinB | input | max(parity,1) | Port B write parity |
| doutB | output | 2^MODE_B | Port B read data |
| poutB | output | max(parity,1) | Port B read parity |

## Verification
The bench builds the block with MODE_A = 1 (8192x2) and MODE_B = 4 (1024x18), with INIT_ON set and a nonzero INIT_XOR. This pairs a narrow port that has no parity with a wide port that has parity. Eight narrow words then fold into one wide word, which exercises the lane packing, the parity lanes and the initial image through a port that is not 36 bits wide. The two clocks run at the same rate with a 3 ns phase offset, so writes through one port and reads through the other interleave in a known order.

// File: rtl/tdpPkg.sv
`timescale 1ns/1ps
package tdpPkg;
  localparam int ROWS      = 512;
  localparam int ROW_AW    = 9;
  localparam int ROW_DBITS = 32;
  localparam int ROW_BITS  = 36;

  typedef struct packed {
    logic wr;   // commit a write this edge
    logic ld;   // update the output register this edge
    logic clr;  // force the output register to zero
  } portStb_t;

  function automatic int dataWidth(input int mode);
    return 1 << mode;
  endfunction

  function automatic int parWidth(input int mode);
    return (mode >= 3) ? (1 << (mode - 3)) : 0;
  endfunction

  function automatic int parPortWidth(input int mode);
    return (mode >= 3) ? (1 << (mode - 3)) : 1;
  endfunction

  function automatic logic [ROW_BITS-1:0] initRow(input logic [ROW_BITS-1:0] seed, input int r);
    return seed ^ (ROW_BITS'(r) << 16) ^ ROW_BITS'(r);
  endfunction
endpackage

// File: rtl/tdpPortCtrl.sv
`timescale 1ns/1ps
module tdpPortCtrl
  import tdpPkg::*;
(
  input  logic     en,
  input  logic     we,
  input  logic     rstOut,
  output portStb_t stb
);
  always_comb begin
    stb.ld  = en;
    stb.wr  = en & we;
    stb.clr = en & rstOut;
  end
endmodule

// File: rtl/tdpPortPath.sv
`timescale 1ns/1ps
module tdpPortPath
  import tdpPkg::*;
#(
  parameter int MODE = 3,
  parameter bit INIT_ON = 1'b0,
  parameter logic [35:0] INIT_XOR = '0,
  localparam int DW = dataWidth(MODE),
  localparam int PW = parWidth(MODE),
  localparam int PX = parPortWidth(MODE),
  localparam int AW = 14 - MODE
) (
  input  logic                clk,
  input  portStb_t            stb,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       din,
  input  logic [PX-1:0]       pin,
  input  logic [ROW_BITS-1:0] peerRowIn,
  input  logic [ROW_AW-1:0]   peekAddr,
  output logic [ROW_BITS-1:0] peekRowOut,
  output logic [ROW_AW-1:0]   rowIdx,
  output logic [DW-1:0]       dout,
  output logic [PX-1:0]       pout
);
  localparam int LB = 5 - MODE;
  localparam logic [ROW_BITS-1:0] DMASK = {{(ROW_BITS-DW){1'b0}}, {DW{1'b1}}};
  localparam logic [ROW_BITS-1:0] PMASK = (PW > 0) ? {{(ROW_BITS-PX){1'b0}}, {PX{1'b1}}} : '0;

  logic [ROW_BITS-1:0] bank [ROWS];
  logic [ROW_BITS-1:0] ownRow, logicalRow, wrMask, wrVal, nextOwn;
  logic [DW-1:0]       readD;
  logic [PX-1:0]       readP, wrP;
  int                  laneIdx, dOff, pOff;

  initial begin
    for (int r = 0; r < ROWS; r++) begin
      bank[r] = INIT_ON ? initRow(INIT_XOR, r) : '0;
    end
  end

  always_comb begin
    rowIdx     = ROW_AW'(addr >> LB);
    laneIdx    = int'(addr) & ((1 << LB) - 1);
    dOff       = laneIdx * DW;
    pOff       = laneIdx * PW;
    ownRow     = bank[rowIdx];
    logicalRow = ownRow ^ peerRowIn;
    readD      = logicalRow[dOff +: DW];
    readP      = (PW > 0) ? logicalRow[ROW_DBITS + pOff +: PX] : '0;
    wrP        = (PW > 0) ? pin : '0;
    wrMask     = (DMASK << dOff) | (PMASK << (ROW_DBITS + pOff));
    wrVal      = (ROW_BITS'(din) << dOff) | (ROW_BITS'(wrP) << (ROW_DBITS + pOff));
    nextOwn    = (ownRow & ~wrMask) | ((wrVal ^ peerRowIn) & wrMask);
    peekRowOut = bank[peekAddr];
  end

  always_ff @(posedge clk) begin
    if (stb.wr) bank[rowIdx] <= nextOwn;
    if (stb.ld) begin
      if (stb.clr) begin
        dout <= '0;
        pout <= '0;
      end else if (stb.wr) begin
        dout <= din;
        pout <= wrP;
      end else begin
        dout <= readD;
        pout <= readP;
      end
    end
  end
endmodule

// File: rtl/mwTdpRam.sv
`timescale 1ns/1ps
module mwTdpRam
  import tdpPkg::*;
#(
  parameter int MODE_A = 3,
  parameter int MODE_B = 5,
  parameter bit INIT_ON = 1'b0,
  parameter logic [35:0] INIT_XOR = '0,
  localparam int DWA = dataWidth(MODE_A),
  localparam int PXA = parPortWidth(MODE_A),
  localparam int AWA = 14 - MODE_A,
  localparam int DWB = dataWidth(MODE_B),
  localparam int PXB = parPortWidth(MODE_B),
  localparam int AWB = 14 - MODE_B
) (
  input  logic           clkA,
  input  logic           enA,
  input  logic           weA,
  input  logic           rstOutA,
  input  logic [AWA-1:0] addrA,
  input  logic [DWA-1:0] dinA,
  input  logic [PXA-1:0] pinA,
  output logic [DWA-1:0] doutA,
  output logic [PXA-1:0] poutA,
  input  logic           clkB,
  input  logic           enB,
  input  logic           weB,
  input  logic           rstOutB,
  input  logic [AWB-1:0] addrB,
  input  logic [DWB-1:0] dinB,
  input  logic [PXB-1:0] pinB,
  output logic [DWB-1:0] doutB,
  output logic [PXB-1:0] poutB
);
  portStb_t            stbA, stbB;
  logic [ROW_AW-1:0]   rowA, rowB;
  logic [ROW_BITS-1:0] peekA, peekB;

  tdpPortCtrl uCtrlA (.en(enA), .we(weA), .rstOut(rstOutA), .stb(stbA));
  tdpPortCtrl uCtrlB (.en(enB), .we(weB), .rstOut(rstOutB), .stb(stbB));

  tdpPortPath #(.MODE(MODE_A), .INIT_ON(INIT_ON), .INIT_XOR(INIT_XOR)) uPathA (
    .clk(clkA), .stb(stbA), .addr(addrA), .din(dinA), .pin(pinA),
    .peerRowIn(peekB), .peekAddr(rowB), .peekRowOut(peekA), .rowIdx(rowA),
    .dout(doutA), .pout(poutA));

  tdpPortPath #(.MODE(MODE_B), .INIT_ON(1'b0), .INIT_XOR('0)) uPathB (
    .clk(clkB), .stb(stbB), .addr(addrB), .din(dinB), .pin(pinB),
    .peerRowIn(peekA), .peekAddr(rowA), .peekRowOut(peekB), .rowIdx(rowB),
    .dout(doutB), .pout(poutB));
endmodule

// File: rtl/tdpCheck.sv
`timescale 1ns/1ps
module tdpCheck #(
  parameter int DWA = 1,
  parameter int PXA = 1,
  parameter int DWB = 1,
  parameter int PXB = 1
) (
  input logic           clkA,
  input logic           enA,
  input logic           weA,
  input logic           rstOutA,
  input logic [DWA-1:0] dinA,
  input logic [DWA-1:0] doutA,
  input logic [PXA-1:0] poutA,
  input logic           clkB,
  input logic           enB,
  input logic           weB,
  input logic           rstOutB,
  input logic [DWB-1:0] dinB,
  input logic [DWB-1:0] doutB,
  input logic [PXB-1:0] poutB
);
  logic primedA = 1'b0;
  logic primedB = 1'b0;
  always_ff @(posedge clkA) if (enA && rstOutA) primedA <= 1'b1;
  always_ff @(posedge clkB) if (enB && rstOutB) primedB <= 1'b1;

  AST_CLR_A: assert property (@(posedge clkA) disable iff (!primedA)
    (enA && rstOutA) |=> (doutA == '0 && poutA == '0)); // R9
  AST_CLR_B: assert property (@(posedge clkB) disable iff (!primedB)
    (enB && rstOutB) |=> (doutB == '0 && poutB == '0)); // R9
  AST_HOLD_A: assert property (@(posedge clkA) disable iff (!primedA)
    !enA |=> ($stable(doutA) && $stable(poutA))); // R8
  AST_HOLD_B: assert property (@(posedge clkB) disable iff (!primedB)
    !enB |=> ($stable(doutB) && $stable(poutB))); // R8
  AST_WRFIRST_A: assert property (@(posedge clkA) disable iff (!primedA)
    (enA && weA && !rstOutA) |=> (doutA == $past(dinA))); // R7
  AST_WRFIRST_B: assert property (@(posedge clkB) disable iff (!primedB)
    (enB && weB && !rstOutB) |=> (doutB == $past(dinB))); // R7
endmodule

bind mwTdpRam tdpCheck #(.DWA(DWA), .PXA(PXA), .DWB(DWB), .PXB(PXB)) uChk (
  .clkA(clkA), .enA(enA), .weA(weA), .rstOutA(rstOutA), .dinA(dinA),
  .doutA(doutA), .poutA(poutA),
  .clkB(clkB), .enB(enB), .weB(weB), .rstOutB(rstOutB), .dinB(dinB),
  .doutB(doutB), .poutB(poutB));

// File: tb/tb_mwTdpRam.sv
`timescale 1ns/1ps
module tb_mwTdpRam;
  localparam int MA = 1;
  localparam int MB = 4;
  localparam logic [35:0] SEED = 36'h9_C3A5_0F0F;
  localparam int DWA = 1 << MA, AWA = 14 - MA, PXA = 1;
  localparam int DWB = 1 << MB, AWB = 14 - MB, PXB = 2;

  logic clkA = 1'b0, clkB = 1'b0;
  logic enA, weA, rsA, enB, weB, rsB;
  logic [AWA-1:0] addrA; logic [DWA-1:0] dinA; logic [PXA-1:0] pinA;
  logic [AWB-1:0] addrB; logic [DWB-1:0] dinB; logic [PXB-1:0] pinB;
  logic [DWA-1:0] doutA; logic [PXA-1:0] poutA;
  logic [DWB-1:0] doutB; logic [PXB-1:0] poutB;

  int total = 0, bad = 0;
  string tagA = "R9", tagB = "R9";

  logic [16383:0] mData;
  logic [2047:0]  mPar;
  logic [31:0] expDA = '0, expDB = '0;
  logic [3:0]  expPA = '0, expPB = '0;

  always #4 clkA = ~clkA;
  initial begin #3; forever #4 clkB = ~clkB; end

  mwTdpRam #(.MODE_A(MA), .MODE_B(MB), .INIT_ON(1'b1), .INIT_XOR(SEED)) dut (
    .clkA(clkA), .enA(enA), .weA(weA), .rstOutA(rsA), .addrA(addrA), .dinA(dinA),
    .pinA(pinA), .doutA(doutA), .poutA(poutA),
    .clkB(clkB), .enB(enB), .weB(weB), .rstOutB(rsB), .addrB(addrB), .dinB(dinB),
    .pinB(pinB), .doutB(doutB), .poutB(poutB));

  // Behavioural reference: flat bit spaces, R3/R4 packing, R11 image.
  initial begin
    for (int r = 0; r < 512; r++) begin
      logic [35:0] v;
      v = SEED ^ (36'(r) << 16) ^ 36'(r);
      for (int j = 0; j < 32; j++) mData[r*32+j] = v[j];
      for (int j = 0; j < 4; j++)  mPar[r*4+j]   = v[32+j];
    end
  end

  task automatic applyOp(input int m, input bit en, input bit we, input bit rs, input int addr,
                         input logic [31:0] d, input logic [3:0] p,
                         inout logic [31:0] eD, inout logic [3:0] eP);
    int dw; int pw;
    dw = 1 << m;
    pw = (m >= 3) ? (1 << (m - 3)) : 0;
    if (!en) return;
    if (we) begin
      for (int i = 0; i < dw; i++) mData[addr*dw+i] = d[i];
      for (int i = 0; i < pw; i++) mPar[addr*pw+i]  = p[i];
    end
    eD = '0; eP = '0;
    if (!rs) begin
      for (int i = 0; i < dw; i++) eD[i] = mData[addr*dw+i];
      for (int i = 0; i < pw; i++) eP[i] = mPar[addr*pw+i];
    end
  endtask

  always @(posedge clkA) applyOp(MA, enA, weA, rsA, int'(addrA), 32'(dinA), 4'(pinA), expDA, expPA);
  always @(posedge clkB) applyOp(MB, enB, weB, rsB, int'(addrB), 32'(dinB), 4'(pinB), expDB, expPB);

  task automatic cmp(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic tick(input bit eA, input bit wA, input bit rA, input int aA, input logic [31:0] dA,
                      input logic [3:0] pA, input string tA,
                      input bit eB, input bit wB, input bit rB, input int aB, input logic [31:0] dB,
                      input logic [3:0] pB, input string tB);
    enA = eA; weA = wA; rsA = rA; addrA = AWA'(aA); dinA = dA[DWA-1:0]; pinA = pA[PXA-1:0];
    enB = eB; weB = wB; rsB = rB; addrB = AWB'(aB); dinB = dB[DWB-1:0]; pinB = pB[PXB-1:0];
    tagA = tA; tagB = tB;
    @(negedge clkA);
    cmp(tagA, "doutA", 32'(doutA), expDA);
    cmp("R2", "poutA", 32'(poutA), 32'(expPA));
    cmp(tagB, "doutB", 32'(doutB), expDB);
    cmp({tagB, " R2"}, "poutB", 32'(poutB), 32'(expPB));
  endtask

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9 reset state: clear both output registers
    tick(1,0,1, 0,0,0,"R9", 1,0,1, 0,0,0,"R9");
    // R11 initial image read through both widths (R4 parity lanes on B)
    tick(1,0,0, 0,0,0,"R11", 1,0,0, 0,0,0,"R11 R4");
    tick(1,0,0, 17,0,0,"R11", 1,0,0, 3,0,0,"R11 R4");
    tick(1,0,0, 8191,0,0,"R11 R1", 1,0,0, 1023,0,0,"R11 R1");
    // R7 write-first on A over eight 2-bit lanes; B disabled with we high (R8)
    for (int k = 0; k < 8; k++)
      tick(1,1,0, k, 32'((k*3+1) & 3), 0, "R7 R3", 0,1,0, 0, 32'hFFFF, 4'h3, "R8");
    // R5/R3 cross-width read of what A wrote
    tick(1,0,0, 3,0,0,"R6", 1,0,0, 0,0,0,"R5 R3");
    // R7 on B with parity
    tick(0,0,0, 0,0,0,"R8", 1,1,0, 5, 32'hBEEF, 4'h2, "R7 R4");
    for (int k = 40; k < 48; k++)
      tick(1,0,0, k,0,0,"R5 R3", 1,0,0, 5,0,0,"R6 R4");
    // R8: disabled write leaves storage and output alone
    tick(0,1,0, 40, 32'h0, 0, "R8", 0,0,0, 0,0,0,"R8");
    tick(1,0,0, 40,0,0,"R8", 1,0,0, 5,0,0,"R8 R5");
    // R9: clear with write still writes
    tick(1,1,1, 41, 32'h2, 0, "R9", 1,1,1, 6, 32'h1234, 4'h1, "R9");
    tick(1,0,0, 41,0,0,"R9", 1,0,0, 6,0,0,"R9");
    // R10: rstOut without enable has no effect
    tick(0,0,1, 0,0,0,"R10", 0,0,1, 0,0,0,"R10");
    tick(0,0,1, 0,0,0,"R10", 0,0,1, 0,0,0,"R10");
    // Mixed traffic in a small window so the ports collide on rows (R1/R5/R6)
    for (int n = 0; n < 400; n++) begin
      int ra, rb;
      ra = $urandom;
      rb = $urandom;
      tick(ra[0] | ra[1], ra[2], (ra[3:0] == 4'hF), int'(ra[31:26]) + 64, 32'($urandom), 4'($urandom), "R6 R5",
           rb[0] | rb[1], rb[2], (rb[3:0] == 4'hF), int'(rb[31:29]) + 8, 32'($urandom), 4'($urandom), "R6 R1");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule